// File: doc/BRIEF.md
# Interleaved Golay Word Fast-Path Corrector

This block corrects a 24-bit memory word protected by the extended (24,12) Golay code in a single pass. In the stored word the twelve check bits and the twelve data bits alternate, starting with a check bit. The decoder forms the 12-bit syndrome and corrects the error patterns that occur most often in memory. These are any one flipped bit, any two flipped neighbouring bits, and any three flipped neighbouring bits whose middle bit is a data bit. It returns the twelve data bits together with two flags: one says a correction was made, the other says the syndrome cannot be resolved here.

A word flagged as unresolvable is meant to go to a slower full decoder outside this block. It can carry up to three scattered errors, or four errors that have only been detected. The layout places check bits k and k+1 on either side of data bit k. Because of this, one masked comparator per data bit covers that bit's single, double and triple patterns together. The output stage can be a register (one cycle of latency) or purely combinational, chosen by a parameter.

Top module: `golay_adj_dec`

## Requirements
- R1: Stored bit 2j holds check bit j and stored bit 2k+1 holds data bit k. A clean word has check bits p = B·d over GF(2), where B is a symmetric 12x12 matrix. For rows j<11 and columns k<11, B[j][k] = g[(j+k) mod 11], with g[10:0] = 11'b01000111011. Column 11 and row 11 are all ones, except B[11][11] = 0.
- R2: A word with a zero syndrome returns its data bits unchanged, and both flags stay low.
- R3: A single flipped data bit is restored and the corrected flag is raised.
- R4: A single flipped check bit leaves the data output equal to the stored data and raises the corrected flag.
- R5: Any two flipped neighbouring stored bits (positions i and i+1) are corrected, and the corrected flag is raised.
- R6: Any three flipped neighbouring stored bits whose middle bit is a data bit are corrected, and the corrected flag is raised.
- R7: Any other error pattern of weight two, three or four raises the unresolvable flag, keeps the corrected flag low and returns the received data bits unmodified. No miscorrection occurs.
- R8: The two flags are never high together, and the data output differs from the received data bits in at most one position.
- R9: With the registered stage (REG_OUT=1), results appear one clock after the word is presented. out_valid follows in_valid with one cycle of delay. Both flags are low whenever out_valid is low. Reset clears out_valid, the flags and the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | The word on in_word is to be decoded |
| in_word | input | 24 | Stored word, check and data bits interleaved |
| out_valid | output | 1 | Result on the outputs is valid |
| out_data | output | 12 | Corrected (or passed-through) data bits |
| out_corrected | output | 1 | A correctable pattern was found and fixed |
| out_uncorrectable | output | 1 | Non-zero syndrome that no comparator matched |

## Verification
The checker assumes in_word is fully known in every cycle where in_valid is high. It also assumes the output stage's latency matches the REG_OUT value it is given, because it relates each result to the word presented one cycle earlier. The bench keeps within these assumptions. It drives every input to a known value at the falling edge and builds each stimulus word from a freshly encoded random data word with a chosen error mask. Every error mask of weight one to four is applied once, and idle cycles are inserted so the valid pipeline is exercised.

// File: rtl/golay_dec_pkg.sv
package golay_dec_pkg;

    localparam int DATA_W = 12;
    localparam int CHK_W  = 12;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int CYC_W  = CHK_W - 1;

    // generator seed for the cyclic part of the check matrix
    localparam logic [CYC_W-1:0] GEN_SEED = 11'b01000111011;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              corr;
        logic              unc;
    } dec_out_t;

    function automatic logic b_bit(input int j, input int k);
        if (j == CYC_W && k == CYC_W) return 1'b0;
        if (j == CYC_W || k == CYC_W) return 1'b1;
        return GEN_SEED[(j + k) % CYC_W];
    endfunction

    // row j of B: which data bits feed check bit j
    function automatic logic [DATA_W-1:0] b_row(input int j);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < DATA_W; k++) r[k] = b_bit(j, k);
        return r;
    endfunction

    // column k of B: syndrome of a lone error on data bit k
    function automatic logic [CHK_W-1:0] b_col(input int k);
        logic [CHK_W-1:0] c;
        for (int j = 0; j < CHK_W; j++) c[j] = b_bit(j, k);
        return c;
    endfunction

    // syndrome rows compared for data bit k: the rows of its
    // neighbouring check bits are left out
    function automatic logic [CHK_W-1:0] data_mask(input int k);
        logic [CHK_W-1:0] m;
        m = '1;
        m[k] = 1'b0;
        if (k + 1 < CHK_W) m[k+1] = 1'b0;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] word_data(input logic [WORD_W-1:0] w);
        logic [DATA_W-1:0] d;
        for (int k = 0; k < DATA_W; k++) d[k] = w[2*k+1];
        return d;
    endfunction

    function automatic logic [CHK_W-1:0] word_chk(input logic [WORD_W-1:0] w);
        logic [CHK_W-1:0] c;
        for (int j = 0; j < CHK_W; j++) c[j] = w[2*j];
        return c;
    endfunction

endpackage

// File: rtl/golay_syndrome.sv
module golay_syndrome
    import golay_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic [CHK_W-1:0]  syn_o
);
    logic [CHK_W-1:0] rx_chk;

    assign rx_data_o = word_data(word_i);
    assign rx_chk    = word_chk(word_i);

    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam logic [DATA_W-1:0] ROW = b_row(j);
        assign syn_o[j] = rx_chk[j] ^ (^(rx_data_o & ROW));
    end
endmodule

// File: rtl/golay_match.sv
module golay_match
    import golay_dec_pkg::*;
(
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] hit_data_o,
    output logic [CHK_W-1:0]  hit_chk_o
);
    // one masked comparator per data bit covers single, both pairs
    // and the centred triple
    for (genvar k = 0; k < DATA_W; k++) begin : g_data
        localparam logic [CHK_W-1:0] COL  = b_col(k);
        localparam logic [CHK_W-1:0] MASK = data_mask(k);
        assign hit_data_o[k] = (((syn_i ^ COL) & MASK) == '0);
    end

    // full-width comparator per check bit
    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        localparam logic [CHK_W-1:0] UNIT = CHK_W'(1) << j;
        assign hit_chk_o[j] = (syn_i == UNIT);
    end
endmodule

// File: rtl/golay_fix.sv
module golay_fix
    import golay_dec_pkg::*;
(
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic [DATA_W-1:0] hit_data_i,
    input  logic [CHK_W-1:0]  hit_chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              unc_o
);
    logic any_hit;
    logic syn_nz;

    always_comb begin
        any_hit = (|hit_data_i) | (|hit_chk_i);
        syn_nz  = |syn_i;
        data_o  = rx_data_i ^ hit_data_i;
        corr_o  = any_hit;
        unc_o   = syn_nz & ~any_hit;
    end
endmodule

// File: rtl/golay_adj_dec.sv
module golay_adj_dec
    import golay_dec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_corrected,
    output logic              out_uncorrectable
);
    logic [DATA_W-1:0] rx_data;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] hit_data;
    logic [CHK_W-1:0]  hit_chk;
    logic [DATA_W-1:0] fix_data;
    logic              fix_corr;
    logic              fix_unc;

    dec_out_t res_d;
    dec_out_t res_q;

    golay_syndrome u_syn (
        .word_i    (in_word),
        .rx_data_o (rx_data),
        .syn_o     (syn)
    );

    golay_match u_match (
        .syn_i      (syn),
        .hit_data_o (hit_data),
        .hit_chk_o  (hit_chk)
    );

    golay_fix u_fix (
        .rx_data_i  (rx_data),
        .syn_i      (syn),
        .hit_data_i (hit_data),
        .hit_chk_i  (hit_chk),
        .data_o     (fix_data),
        .corr_o     (fix_corr),
        .unc_o      (fix_unc)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        res_d.data  = fix_data;
        res_d.corr  = in_valid & fix_corr;
        res_d.unc   = in_valid & fix_unc;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign out_valid         = res_q.valid;
    assign out_data          = res_q.data;
    assign out_corrected     = res_q.corr;
    assign out_uncorrectable = res_q.unc;
endmodule

// File: rtl/golay_adj_dec_chk.sv
module golay_adj_dec_chk
    import golay_dec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_corrected,
    input logic              out_uncorrectable
);
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corrected && out_uncorrectable));

    assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_corrected && !out_uncorrectable));

    if (REG_OUT) begin : g_seq
        assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        assert_one_bit_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($countones(out_data ^ word_data($past(in_word))) <= 1));

        assert_clean_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_corrected && !out_uncorrectable)
                |-> (out_data == word_data($past(in_word))));

        assert_uncorr_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_uncorrectable) |-> (out_data == word_data($past(in_word))));
    end else begin : g_comb
        assert_valid_same_R9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);

        assert_one_bit_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($countones(out_data ^ word_data(in_word)) <= 1));

        assert_clean_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_corrected && !out_uncorrectable)
                |-> (out_data == word_data(in_word)));

        assert_uncorr_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_uncorrectable) |-> (out_data == word_data(in_word)));
    end
endmodule

bind golay_adj_dec golay_adj_dec_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_valid          (in_valid),
    .in_word           (in_word),
    .out_valid         (out_valid),
    .out_data          (out_data),
    .out_corrected     (out_corrected),
    .out_uncorrectable (out_uncorrectable)
);

// File: tb/golay_adj_dec_tb.sv
module golay_adj_dec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_word = '0;
    logic        out_valid;
    logic [11:0] out_data;
    logic        out_corrected;
    logic        out_uncorrectable;

    int checks = 0;
    int failures = 0;

    logic [11:0] brow [12];
    logic [14:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    golay_adj_dec #(.REG_OUT(1'b1)) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .in_valid          (in_valid),
        .in_word           (in_word),
        .out_valid         (out_valid),
        .out_data          (out_data),
        .out_corrected     (out_corrected),
        .out_uncorrectable (out_uncorrectable)
    );

    // check matrix rows built from the rule stated in R1
    function automatic void build_b();
        logic [10:0] g = 11'b01000111011;
        for (int j = 0; j < 11; j++) begin
            logic [10:0] rot = (g >> j) | (g << (11 - j));
            brow[j] = {1'b1, rot};
        end
        brow[11] = 12'h7FF;
    endfunction

    function automatic logic [23:0] encode(input logic [11:0] d);
        logic [23:0] w;
        for (int j = 0; j < 12; j++) begin
            w[2*j]   = ^(d & brow[j]);
            w[2*j+1] = d[j];
        end
        return w;
    endfunction

    function automatic logic [11:0] raw_data(input logic [23:0] w);
        logic [11:0] d;
        for (int k = 0; k < 12; k++) d[k] = w[2*k+1];
        return d;
    endfunction

    task automatic compare(input logic [14:0] e, input string tag);
        logic [14:0] got = {out_valid, out_data, out_corrected, out_uncorrectable};
        checks++;
        if (e[14]) begin
            if (got != e) begin
                failures++;
                $display("FAIL %s: got v=%0b d=%03h c=%0b u=%0b exp v=%0b d=%03h c=%0b u=%0b",
                         tag, got[14], got[13:2], got[1], got[0],
                         e[14], e[13:2], e[1], e[0]);
            end
        end else if (got[14] || got[1] || got[0]) begin
            failures++;
            $display("FAIL %s: idle got v=%0b c=%0b u=%0b exp all 0",
                     tag, got[14], got[1], got[0]);
        end
    endtask

    // one cycle: check result of the previous word, drive a new one
    task automatic step(input logic vld, input logic [23:0] w,
                        input logic [14:0] e, input string tag);
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        in_valid = vld;
        in_word  = w;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, $urandom(), 15'd0, tag);
    endtask

    task automatic run_err(input logic [23:0] e);
        logic [11:0] d  = 12'($urandom());
        logic [23:0] rx = encode(d) ^ e;
        int  w = $countones(e);
        int  lo = 0;
        bit  ok;
        string tag;
        for (int i = 23; i >= 0; i--) if (e[i]) lo = i;
        if (w <= 1)      ok = 1'b1;
        else if (w == 2) ok = (e == (24'd3 << lo));
        else if (w == 3) ok = (e == (24'd7 << lo)) && (lo % 2 == 0);
        else             ok = 1'b0;
        if (w == 0)                tag = "R2 clean";
        else if (w == 1 && lo % 2 == 0) tag = $sformatf("R4 chk e=%06h", e);
        else if (w == 1)           tag = $sformatf("R3 data e=%06h", e);
        else if (ok && w == 2)     tag = $sformatf("R5 pair e=%06h", e);
        else if (ok && w == 3)     tag = $sformatf("R6 triple e=%06h", e);
        else                       tag = $sformatf("R7 uncorr e=%06h", e);
        step(1'b1, rx,
             {1'b1, (ok ? d : raw_data(rx)), ok && (w > 0), !ok}, tag);
    endtask

    initial begin : watchdog
        #1_500_000;
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        build_b();
        repeat (3) @(negedge clk);
        // R9 reset state
        checks++;
        if (out_valid || out_corrected || out_uncorrectable || out_data != 12'h000) begin
            failures++;
            $display("FAIL R9 reset: got v=%0b d=%03h c=%0b u=%0b exp all 0",
                     out_valid, out_data, out_corrected, out_uncorrectable);
        end
        rst_n = 1'b1;

        // R2 clean words, including extremes
        step(1'b1, encode(12'h000), {1'b1, 12'h000, 2'b00}, "R2 zero word");
        step(1'b1, encode(12'hFFF), {1'b1, 12'hFFF, 2'b00}, "R2 ones word");
        for (int i = 0; i < 6; i++) run_err(24'd0);
        idle("R9 idle after clean");

        // R3 R4 all single errors
        for (int a = 0; a < 24; a++) run_err(24'd1 << a);
        idle("R9 idle after singles");

        // R5 R7 all weight-2 patterns
        for (int a = 0; a < 24; a++)
            for (int b = a + 1; b < 24; b++)
                run_err((24'd1 << a) | (24'd1 << b));
        idle("R9 idle after pairs");

        // R6 R7 all weight-3 patterns
        for (int a = 0; a < 24; a++)
            for (int b = a + 1; b < 24; b++)
                for (int c = b + 1; c < 24; c++)
                    run_err((24'd1 << a) | (24'd1 << b) | (24'd1 << c));
        idle("R9 idle after triples");

        // R7 all weight-4 patterns
        for (int a = 0; a < 24; a++)
            for (int b = a + 1; b < 24; b++)
                for (int c = b + 1; c < 24; c++)
                    for (int f = c + 1; f < 24; f++)
                        run_err((24'd1 << a) | (24'd1 << b) | (24'd1 << c) | (24'd1 << f));

        // R5 R6 adjacent patterns again over fresh data words
        for (int r = 0; r < 4; r++) begin
            for (int a = 0; a < 23; a++) run_err(24'd3 << a);
            for (int a = 0; a < 22; a += 2) run_err(24'd7 << a);
        end

        idle("R9 flush");
        idle("R9 flush");
        @(negedge clk);
        while (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule